// File: doc/BRIEF.md
# Probe Output Router with Two-Input Reset Arm

This block puts internal probe signals from a video design onto a small number of general-purpose output pads. The probes are the system clock, the system clock divided by two and by four, twenty-four colour bits, two three-wire serial interfaces, the blanking flags, a texture drive-enable, three texture input loopback bits, three mode bits and the raster position counters. Each of the six pads has its own 6-bit select word. The select words normally come from logic-analyser lines, so each pad can show any of the 64 sources independently of the other pads.

Select value zero does not pick one common source. Each pad has its own fallback source for that value. If the select bus is dead or stuck at zero, the pads still show six different, useful signals.

The same block also makes the design's active-low reset from two arm inputs. Reset is held whenever the two arm inputs are equal. The design only runs once they are deliberately driven to opposite levels. Power-up states of all zeros or all ones therefore both keep the design in reset.

Top module: `dbg_probe_mux`

## Requirements
- R1: `sys_rst_n` is low whenever `arm_a` equals `arm_b`. When the two become equal, `sys_rst_n` goes low at once, without waiting for a clock edge. This holds for both 0/0 and 1/1.
- R2: After `arm_a` and `arm_b` become different, `sys_rst_n` stays low through the first rising clock edge and goes high at the second rising edge.
- R3: While `sys_rst_n` is low, every registered pad output is 0, whatever the probe values are.
- R4: Pad k uses select field `sel_flat[6k+5:6k]`. A nonzero select s other than 2 makes the pad show source s, as sampled at the previous rising edge. The source map is: 1 = constant 1; 5..28 = `pix_rgb[s-5]`; 29..31 = `spi_a[s-29]`; 32..34 = `spi_b[s-32]`; 35 = `hblank`; 36 = `vblank`; 37 = `tex_oe`; 38..40 = `tex_din[s-38]`; 41..43 = `mode_bits[s-41]`; 44..53 = `hpos[s-44]`; 54..63 = `vpos[s-54]`.
- R5: Select 0 picks a fallback source that differs per pad: pad 0 = `hblank`, pad 1 = `vblank`, pad 2 = clk/2, pad 3 = clk/4, pad 4 = `hpos[0]`, pad 5 = `vpos[0]`. These outputs are registered like those in R4.
- R6: Select 2 routes `clk` to the pad combinationally, with no register in the path. The pad is high while `clk` is high and low while it is low, even during reset.
- R7: Sources 3 (clk/2) and 4 (clk/4) are bits 0 and 1 of a 2-bit up-counter. The counter holds 0 while `sys_rst_n` is low and then advances by one at every rising edge. Counting from the edge that releases reset, the counter has the value n-1 after the n-th edge that follows.
- R8: The select words are independent. Changing one pad's select word leaves every other pad's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also a probe source |
| arm_a | input | 1 | Reset arm input A |
| arm_b | input | 1 | Reset arm input B |
| sel_flat | input | 36 | Six packed 6-bit select words, pad k at bits 6k+5:6k |
| pix_rgb | input | 24 | Colour probe bits |
| spi_a | input | 3 | First serial interface probe (select, clock, data) |
| spi_b | input | 3 | Second serial interface probe |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| tex_oe | input | 1 | Texture data drive-enable |
| tex_din | input | 3 | Texture data-in loopback |
| mode_bits | input | 3 | Mode bits |
| hpos | input | 10 | Horizontal position |
| vpos | input | 10 | Vertical position |
| gp_out | output | 6 | Routed probe outputs |
| sys_rst_n | output | 1 | Active-low design reset |

## Verification
A divider counter that does not clear, or that advances one edge late, shows up on the clk/2 and clk/4 fallback pads. The wrong phase appears within the first four edges after reset is released. A bad entry in the source map, or a wrong fallback, shows up on the affected pad one edge after its select word is applied. A synchroniser with the wrong depth moves the release of `sys_rst_n` by a whole cycle, which is visible on the second edge after the arm inputs differ. A missing asynchronous path shows up as `sys_rst_n` staying high after the arm inputs become equal, before the next edge arrives.

// File: rtl/dbg_probe_pkg.sv
// Package: shared constants of the probe router.
// It holds the select width, the fixed source indices and the per-pad
// fallback table. It assumes at most six pads, because the fallback
// table only has six distinct entries.
package dbg_probe_pkg;

    localparam int SEL_W       = 6;
    localparam int N_SRC       = 1 << SEL_W;
    localparam int N_GPOUT_DEF = 6;

    localparam int RGB_W  = 24;
    localparam int SPI_W  = 3;
    localparam int LOOP_W = 3;
    localparam int MODE_W = 3;
    localparam int POS_W  = 10;

    localparam int SRC_FALLBACK = 0;
    localparam int SRC_HIGH     = 1;
    localparam int SRC_CLK      = 2;
    localparam int SRC_DIV2     = 3;
    localparam int SRC_DIV4     = 4;
    localparam int SRC_RGB      = 5;
    localparam int SRC_SPIA     = SRC_RGB + RGB_W;
    localparam int SRC_SPIB     = SRC_SPIA + SPI_W;
    localparam int SRC_HBLANK   = SRC_SPIB + SPI_W;
    localparam int SRC_VBLANK   = SRC_HBLANK + 1;
    localparam int SRC_TEXOE    = SRC_VBLANK + 1;
    localparam int SRC_LOOP     = SRC_TEXOE + 1;
    localparam int SRC_MODE     = SRC_LOOP + LOOP_W;
    localparam int SRC_HPOS     = SRC_MODE + MODE_W;
    localparam int SRC_VPOS     = SRC_HPOS + POS_W;

    // Fallback source for select value zero on a given pad
    function automatic logic [SEL_W-1:0] fallback_src(input int lane);
        case (lane)
            0:       fallback_src = SEL_W'(SRC_HBLANK);
            1:       fallback_src = SEL_W'(SRC_VBLANK);
            2:       fallback_src = SEL_W'(SRC_DIV2);
            3:       fallback_src = SEL_W'(SRC_DIV4);
            4:       fallback_src = SEL_W'(SRC_HPOS);
            default: fallback_src = SEL_W'(SRC_VPOS);
        endcase
    endfunction

endpackage

// File: rtl/dbg_lock_reset.sv
// Module: reset arm and synchroniser.
// Reset is held while the two arm inputs are equal. The hold asserts the
// synchroniser chain asynchronously. Release propagates through STAGES
// flops, so it is synchronous to clk. Assumes STAGES >= 2.
module dbg_lock_reset #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arm_a,
    input  logic arm_b,
    output logic rst_n
);

    logic              hold;
    logic [STAGES-1:0] sync_q;

    assign hold = ~(arm_a ^ arm_b);

    // Shift ones into the chain once the arm inputs differ; clear at once on hold
    always_ff @(posedge clk or posedge hold) begin
        if (hold) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dbg_clk_div.sv
// Module: free-running clock divider.
// It is a plain binary up-counter, and bit i toggles at clk/2^(i+1).
// It is cleared synchronously by the arm-derived reset.
module dbg_clk_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] div_q
);

    // Advance the counter every edge, hold zero in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/dbg_src_lane.sv
// Module: one pad's source selector.
// A zero select is replaced by the pad's fallback. The chosen source is
// registered, except for the clock source, which bypasses the register.
// Assumes the fallback is never the clock source.
module dbg_src_lane #(
    parameter int              SEL_W    = 6,
    parameter int              CLK_IDX  = 2,
    parameter logic [SEL_W-1:0] FALLBACK = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        sel,
    input  logic [(1<<SEL_W)-1:0]   src,
    output logic                    pad
);

    logic [SEL_W-1:0] eff_sel;
    logic             pad_q;

    // Resolve the zero select to this pad's fallback
    always_comb begin
        eff_sel = (sel == '0) ? FALLBACK : sel;
    end

    // Register the selected probe bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q <= 1'b0;
        end else begin
            pad_q <= src[eff_sel];
        end
    end

    // The clock source bypasses the register
    always_comb begin
        pad = (eff_sel == SEL_W'(CLK_IDX)) ? clk : pad_q;
    end

endmodule

// File: rtl/dbg_probe_mux.sv
// Module: probe router top.
// It gathers the probe inputs into a 64-entry source bus and gives each pad
// a selector lane. It also makes the design reset from the two arm inputs.
// Assumes N_GPOUT <= 6 and DIV_W >= 2.
module dbg_probe_mux
    import dbg_probe_pkg::*;
#(
    parameter int N_GPOUT     = N_GPOUT_DEF,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic                     clk,
    input  logic                     arm_a,
    input  logic                     arm_b,
    input  logic [N_GPOUT*SEL_W-1:0] sel_flat,
    input  logic [RGB_W-1:0]         pix_rgb,
    input  logic [SPI_W-1:0]         spi_a,
    input  logic [SPI_W-1:0]         spi_b,
    input  logic                     hblank,
    input  logic                     vblank,
    input  logic                     tex_oe,
    input  logic [LOOP_W-1:0]        tex_din,
    input  logic [MODE_W-1:0]        mode_bits,
    input  logic [POS_W-1:0]         hpos,
    input  logic [POS_W-1:0]         vpos,
    output logic [N_GPOUT-1:0]       gp_out,
    output logic                     sys_rst_n
);

    logic [DIV_W-1:0] div_q;
    logic [N_SRC-1:0] src_bus;

    dbg_lock_reset #(.STAGES(SYNC_STAGES)) u_lock (
        .clk   (clk),
        .arm_a (arm_a),
        .arm_b (arm_b),
        .rst_n (sys_rst_n)
    );

    dbg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .div_q (div_q)
    );

    // Pack the probes into the fixed source map
    always_comb begin
        src_bus                        = '0;
        src_bus[SRC_HIGH]              = 1'b1;
        src_bus[SRC_DIV2]              = div_q[0];
        src_bus[SRC_DIV4]              = div_q[1];
        src_bus[SRC_RGB  +: RGB_W]     = pix_rgb;
        src_bus[SRC_SPIA +: SPI_W]     = spi_a;
        src_bus[SRC_SPIB +: SPI_W]     = spi_b;
        src_bus[SRC_HBLANK]            = hblank;
        src_bus[SRC_VBLANK]            = vblank;
        src_bus[SRC_TEXOE]             = tex_oe;
        src_bus[SRC_LOOP +: LOOP_W]    = tex_din;
        src_bus[SRC_MODE +: MODE_W]    = mode_bits;
        src_bus[SRC_HPOS +: POS_W]     = hpos;
        src_bus[SRC_VPOS +: POS_W]     = vpos;
    end

    for (genvar k = 0; k < N_GPOUT; k++) begin : g_lane
        dbg_src_lane #(
            .SEL_W    (SEL_W),
            .CLK_IDX  (SRC_CLK),
            .FALLBACK (fallback_src(k))
        ) u_lane (
            .clk   (clk),
            .rst_n (sys_rst_n),
            .sel   (sel_flat[k*SEL_W +: SEL_W]),
            .src   (src_bus),
            .pad   (gp_out[k])
        );
    end

endmodule

// File: rtl/dbg_probe_mux_chk.sv
// Module: assertion checker bound to the probe router.
// It only observes the top-level ports. Assumes the default of six pads.
module dbg_probe_mux_chk
    import dbg_probe_pkg::*;
(
    input logic                         clk,
    input logic                         arm_a,
    input logic                         arm_b,
    input logic [N_GPOUT_DEF*SEL_W-1:0] sel_flat,
    input logic [N_GPOUT_DEF-1:0]       gp_out,
    input logic                         sys_rst_n
);

    logic [N_GPOUT_DEF-1:0] clk_lane;

    // Pads whose select word asks for the raw clock
    always_comb begin
        for (int k = 0; k < N_GPOUT_DEF; k++) begin
            clk_lane[k] = (sel_flat[k*SEL_W +: SEL_W] == SEL_W'(SRC_CLK));
        end
    end

    // R1
    arm_equal_holds_rst_chk: assert property (@(negedge clk)
        (arm_a == arm_b) |-> !sys_rst_n);

    // R2
    rst_release_after_arm_chk: assert property (@(posedge clk)
        disable iff (arm_a == arm_b)
        $rose(sys_rst_n) |-> $past(arm_a != arm_b));

    // R3
    pads_clear_in_rst_chk: assert property (@(posedge clk)
        !sys_rst_n |=> ((gp_out & ~clk_lane) == '0));

    // R6
    clk_pad_low_at_edge_chk: assert property (@(posedge clk)
        disable iff (!sys_rst_n)
        ((gp_out & clk_lane) == '0));

    for (genvar k = 0; k < N_GPOUT_DEF; k++) begin : g_high
        // R4
        high_src_reaches_pad_chk: assert property (@(posedge clk)
            disable iff (!sys_rst_n)
            (sel_flat[k*SEL_W +: SEL_W] == SEL_W'(SRC_HIGH)) |=> gp_out[k]);
    end

endmodule

bind dbg_probe_mux dbg_probe_mux_chk u_chk (
    .clk       (clk),
    .arm_a     (arm_a),
    .arm_b     (arm_b),
    .sel_flat  (sel_flat),
    .gp_out    (gp_out),
    .sys_rst_n (sys_rst_n)
);

// File: tb/tb_dbg_probe_mux.sv
// Scoreboard bench for the probe router: the driver queues the expected
// pad values and the monitor compares them after the next rising edge.
module tb_dbg_probe_mux;

    logic        clk = 1'b0;
    logic        arm_a, arm_b;
    logic [35:0] sel_flat;
    logic [23:0] pix_rgb;
    logic [2:0]  spi_a, spi_b, tex_din, mode_bits;
    logic        hblank, vblank, tex_oe;
    logic [9:0]  hpos, vpos;
    logic [5:0]  gp_out;
    logic        sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [5:0] exp;
        logic [5:0] mask;
        string      tag;
    } item_t;
    item_t sb_q[$];

    localparam logic [63:0] PAT = 64'hA5C3_9E17_4B2D_F068;

    always #10 clk = ~clk;

    dbg_probe_mux dut (
        .clk(clk), .arm_a(arm_a), .arm_b(arm_b), .sel_flat(sel_flat),
        .pix_rgb(pix_rgb), .spi_a(spi_a), .spi_b(spi_b), .hblank(hblank),
        .vblank(vblank), .tex_oe(tex_oe), .tex_din(tex_din),
        .mode_bits(mode_bits), .hpos(hpos), .vpos(vpos),
        .gp_out(gp_out), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_probes(input logic [63:0] p);
        pix_rgb   = p[28:5];
        spi_a     = p[31:29];
        spi_b     = p[34:32];
        hblank    = p[35];
        vblank    = p[36];
        tex_oe    = p[37];
        tex_din   = p[40:38];
        mode_bits = p[43:41];
        hpos      = p[53:44];
        vpos      = p[63:54];
    endtask

    task automatic drive_expect(input logic [35:0] s, input logic [63:0] p,
                                input logic [5:0] e, input logic [5:0] m, input string tag);
        item_t it;
        @(negedge clk);
        sel_flat = s;
        set_probes(p);
        it.exp = e; it.mask = m; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare each queued item after the following rising edge
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            @(posedge clk);
            #2;
            check(64'(gp_out & it.mask), 64'(it.exp & it.mask), it.tag);
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        arm_a = 1'b0; arm_b = 1'b1;
        sel_flat = '0;
        set_probes('0);
        #1 arm_b = 1'b0;
        // R3: probes high during reset must not reach the pads
        set_probes(~64'h0);
        repeat (2) @(posedge clk);
        #2;
        check(64'(sys_rst_n), 0, "R1 arms 0/0");
        check(64'(gp_out), 0, "R3 pads in reset");
        // R1: both arms high also holds reset
        @(posedge clk); #3;
        arm_a = 1'b1; arm_b = 1'b1;
        @(posedge clk); #2;
        check(64'(sys_rst_n), 0, "R1 arms 1/1");
        set_probes('0);
        // R2 / R7: release and watch the divided-clock fallbacks
        @(negedge clk);
        arm_b = 1'b0;
        @(posedge clk); #2;
        check(64'(sys_rst_n), 0, "R2 first edge");
        @(posedge clk); #2;
        check(64'(sys_rst_n), 1, "R2 second edge");
        for (int n = 0; n < 5; n++) begin
            @(posedge clk); #2;
            check(64'(gp_out), 64'({n[1], n[0], 2'b00} & 6'b001100), "R7 R5 divider pads");
        end
        // R1: asynchronous assertion between edges
        @(posedge clk); #3;
        arm_b = 1'b1;
        #1;
        check(64'(sys_rst_n), 0, "R1 async");
        @(negedge clk);
        arm_b = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check(64'(sys_rst_n), 1, "R2 re-release");
        // R4 / R8: every mapped source on one pad, others held at constant high
        for (int p = 0; p < 2; p++) begin
            for (int s = 5; s < 64; s++) begin
                logic [63:0] pt;
                logic [35:0] sv;
                logic [5:0]  ev;
                int          ln;
                pt = (p == 0) ? PAT : ~PAT;
                ln = s % 6;
                sv = {6{6'd1}};
                sv[ln*6 +: 6] = 6'(s);
                ev = 6'h3f;
                ev[ln] = pt[s];
                drive_expect(sv, pt, ev, 6'h3f, "R4 R8 source map");
            end
        end
        // R5: fallbacks for select zero on the non-divider pads
        drive_expect('0, 64'(1) << 35 | 64'(1) << 44, 6'b010001, 6'b110011, "R5 fallback");
        drive_expect('0, 64'(1) << 36 | 64'(1) << 54, 6'b100010, 6'b110011, "R5 fallback");
        // R6: clock pad is high just after a rising edge
        drive_expect({{4{6'd1}}, 6'd2, 6'd1}, '0, 6'h3f, 6'h3f, "R6 clk high");
        @(negedge clk); #2;
        check(64'(gp_out), 64'(6'b111101), "R6 clk low");
        @(posedge clk); #5;
        report();
    end

endmodule